// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block takes bytes from a plain synchronous FIFO through a valid/ready input and sends each one as an asynchronous serial frame on a single output line. The frame starts with a start bit, continues with the data bits least significant bit first, adds an optional parity bit and ends with one or two stop bits. The block then returns the line to its resting level.

Every part of the frame format comes from runtime inputs: the data width, whether parity is sent and whether it is even or odd, the number of stop bits, the resting polarity of the line and the bit period in system clock cycles. The block captures all of these inputs when it accepts a byte. A change to them during a frame therefore has no effect until the next frame. A busy flag covers the whole frame, from the start bit to the last stop bit.

Top module: `ser_frame_tx`

## Requirements
- R1: While no frame is in progress, `line_o` equals the live value of `cfg_idle_i`, and `busy_o` is low.
- R2: The start bit is driven to the inverse of the resting level that was captured when the byte was accepted.
- R3: Data bits follow the start bit, least significant bit first. The number of data bits equals `cfg_width_i`, clamped to the range 5..8: a code below 5 sends 5 bits and a code above 8 sends 8 bits.
- R4: When `cfg_par_en_i` was 1 at acceptance, one parity bit follows the last data bit. It is computed over the active data bits only. `cfg_par_odd_i` = 0 gives even parity (the XOR of the data bits) and 1 gives odd parity (the inverse of that XOR).
- R5: Stop bits are driven at the captured resting level. `cfg_stop_i` = 2'b10 gives two stop bits, and every other code gives one.
- R6: Every bit of a frame lasts exactly `cfg_period_i` clock cycles, using the value captured at acceptance. A period of 0 is treated as 1.
- R7: `in_ready_o` is high exactly when `busy_o` is low. A byte is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high, and the start bit appears in the next cycle. `busy_o` stays high from the start bit through the last stop bit. After a frame, `in_ready_o` is high for at least one cycle before the next frame starts.
- R8: All configuration inputs are captured at acceptance. Changing them during a frame does not alter that frame.
- R9: While `rst_ni` is low, `busy_o` is 0, `in_ready_o` is 1 and `line_o` is at the `cfg_idle_i` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_width_i | input | 4 | Data bit count, clamped to 5..8 |
| cfg_par_en_i | input | 1 | Send a parity bit |
| cfg_par_odd_i | input | 1 | Parity type: 0 even, 1 odd |
| cfg_stop_i | input | 2 | 2'b10: two stop bits; any other code: one stop bit |
| cfg_idle_i | input | 1 | Resting line level |
| cfg_period_i | input | 16 | Bit period in clock cycles (0 is treated as 1) |
| in_valid_i | input | 1 | Byte available |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Block can accept a byte |
| busy_o | output | 1 | Frame in progress |
| line_o | output | 1 | Serial output line |

## Verification
The bench drives widths 3, 5, 6, 7, 8 and 12, and runs both parity types with parity on and off. A design that failed to clamp the width, or that computed parity over masked-off bits, would put a wrong bit in the slot right after the data bits. Periods of 0, 1 and several cycles are used, with both resting polarities and all four stop codes. A one-cycle error in the bit counter, or treating a period of 0 as 65536 cycles, would shift every later bit against the cycle-accurate model. Some frames have their configuration scrambled in mid-frame, and some bytes are presented back to back with valid held high. These expose a design that reads its inputs live instead of capturing them, or one that starts the next frame without the required idle cycle.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/ser_tx_timer.sv
module ser_tx_timer #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] period_i,
  input  logic          run_i,
  output logic          bit_done_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q, per_q;
  logic          last;

  assign last       = (cnt_q == per_q - ONE);
  assign bit_done_o = run_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= ONE;
    end else if (load_i) begin
      cnt_q <= '0;
      per_q <= (period_i == '0) ? ONE : period_i;  // zero period acts as one
    end else if (run_i) begin
      cnt_q <= last ? '0 : cnt_q + ONE;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < per_q)); // R6
  AST_PER_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q != '0); // R6
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int WMIN = 5,
  parameter int WW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] cfg_width_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic [1:0]    cfg_stop_i,
  input  logic          cfg_idle_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          bit_done_i,
  output logic          start_o,
  output logic          in_ready_o,
  output logic          busy_o,
  output logic          line_o
);
  localparam int IW = $clog2(DW) + 1;
  localparam logic [IW-1:0] ONE = IW'(1);

  tx_state_e     state_q;
  logic [DW-1:0] sh_q;
  logic [IW-1:0] w_q, idx_q, w_eff;
  logic          par_q, pen_q, two_q, idle_q, stop2_q;
  logic          par_calc;

  always_comb begin
    if (cfg_width_i < WW'(WMIN))     w_eff = IW'(WMIN);
    else if (cfg_width_i > WW'(DW))  w_eff = IW'(DW);
    else                             w_eff = IW'(cfg_width_i);
  end

  always_comb begin
    par_calc = cfg_par_odd_i;
    for (int i = 0; i < DW; i++) begin
      if (IW'(i) < w_eff) par_calc = par_calc ^ in_data_i[i];
    end
  end

  assign in_ready_o = (state_q == ST_IDLE);
  assign busy_o     = !in_ready_o;
  assign start_o    = in_ready_o && in_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      w_q     <= IW'(DW);
      idx_q   <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      two_q   <= 1'b0;
      idle_q  <= 1'b1;
      stop2_q <= 1'b0;
    end else if (start_o) begin
      state_q <= ST_START;
      sh_q    <= in_data_i;
      w_q     <= w_eff;
      idx_q   <= '0;
      par_q   <= par_calc;
      pen_q   <= cfg_par_en_i;
      two_q   <= (cfg_stop_i == 2'b10);
      idle_q  <= cfg_idle_i;
      stop2_q <= 1'b0;
    end else if (bit_done_i) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + ONE;
          if (idx_q == w_q - ONE) begin
            state_q <= pen_q ? ST_PAR : ST_STOP;
            stop2_q <= 1'b0;
          end
        end
        ST_PAR:  state_q <= ST_STOP;
        ST_STOP: begin
          if (two_q && !stop2_q) stop2_q <= 1'b1;
          else                   state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = !idle_q;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      ST_STOP:  line_o = idle_q;
      default:  line_o = cfg_idle_i;
    endcase
  end

  AST_START_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (line_o == !$past(cfg_idle_i))); // R2
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (idx_q < w_q)); // R3
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_done_i) |=> $stable(line_o)); // R6
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> busy_o); // R7
  AST_END_ON_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bit_done_i)); // R7
  AST_STOP_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(line_o) == $past(idle_q)); // R5
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
  parameter int DW   = 8,
  parameter int WMIN = 5,
  parameter int WW   = 4,
  parameter int PW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] cfg_width_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic [1:0]    cfg_stop_i,
  input  logic          cfg_idle_i,
  input  logic [PW-1:0] cfg_period_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          busy_o,
  output logic          line_o
);
  logic start, bit_done;

  ser_tx_timer #(.PW(PW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .period_i  (cfg_period_i),
    .run_i     (busy_o),
    .bit_done_o(bit_done)
  );

  ser_tx_seq #(.DW(DW), .WMIN(WMIN), .WW(WW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_width_i  (cfg_width_i),
    .cfg_par_en_i (cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i),
    .cfg_stop_i   (cfg_stop_i),
    .cfg_idle_i   (cfg_idle_i),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .bit_done_i   (bit_done),
    .start_o      (start),
    .in_ready_o   (in_ready_o),
    .busy_o       (busy_o),
    .line_o       (line_o)
  );

  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o != busy_o); // R7
endmodule

// File: tb/sim_ser_frame_tx.sv
module sim_ser_frame_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cfg_width_i = 4'd8;
  logic        cfg_par_en_i = 1'b0, cfg_par_odd_i = 1'b0, cfg_idle_i = 1'b1;
  logic [1:0]  cfg_stop_i = 2'b01;
  logic [15:0] cfg_period_i = 16'd4;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o, busy_o, line_o;

  int n_run = 0, n_fail = 0, acc_cnt = 0, cyc = 0;
  logic  bit_q[$];
  string tag_q[$];

  ser_frame_tx u0 (.*);

  always #4 clk_i = !clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push_bit(input logic v, input string t, input int p);
    for (int k = 0; k < p; k++) begin bit_q.push_back(v); tag_q.push_back(t); end
  endtask

  // behavioural reference: builds the whole frame's per-cycle line levels at acceptance
  always @(posedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      automatic bit was_empty = (bit_q.size() == 0);
      if (!was_empty) begin void'(bit_q.pop_front()); void'(tag_q.pop_front()); end
      if (was_empty && in_valid_i) begin
        automatic int w = (cfg_width_i < 5) ? 5 : (cfg_width_i > 8) ? 8 : int'(cfg_width_i);
        automatic int p = (cfg_period_i == 0) ? 1 : int'(cfg_period_i);
        automatic logic par = cfg_par_odd_i;
        push_bit(!cfg_idle_i, "R2", p);
        for (int i = 0; i < w; i++) begin push_bit(in_data_i[i], "R3", p); par ^= in_data_i[i]; end
        if (cfg_par_en_i) push_bit(par, "R4", p);
        push_bit(cfg_idle_i, "R5", p);
        if (cfg_stop_i == 2'b10) push_bit(cfg_idle_i, "R5", p);
        acc_cnt++;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(busy_o == 1'b0 && in_ready_o == 1'b1 && line_o == cfg_idle_i, "R9",
          {busy_o, in_ready_o, line_o}, {2'b01, cfg_idle_i});
    end else begin
      automatic bit act = (bit_q.size() != 0);
      if (act) chk(line_o == bit_q[0], tag_q[0], line_o, bit_q[0]);
      else     chk(line_o == cfg_idle_i, "R1", line_o, cfg_idle_i);
      chk(busy_o == act && in_ready_o == !act, "R7", {busy_o, in_ready_o}, {act, !act});
    end
  end

  task automatic send(input logic [7:0] d, input logic [3:0] w, input logic pe, input logic po,
                      input logic [1:0] st, input logic idle, input logic [15:0] per,
                      input bit scramble);
    automatic int a0;
    @(negedge clk_i);
    cfg_width_i = w; cfg_par_en_i = pe; cfg_par_odd_i = po;
    cfg_stop_i = st; cfg_idle_i = idle; cfg_period_i = per;
    in_data_i = d; in_valid_i = 1'b1;
    a0 = acc_cnt;
    do @(negedge clk_i); while (acc_cnt == a0);
    in_valid_i = 1'b0;
    if (scramble) begin  // R8: mid-frame changes must not alter this frame
      cfg_width_i = ~w; cfg_par_en_i = !pe; cfg_par_odd_i = !po;
      cfg_stop_i = ~st; cfg_period_i = per + 16'd3; in_data_i = ~d;
    end
    while (bit_q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    send(8'h66, 4'd8, 0, 0, 2'b01, 1, 16'd4, 0);   // R3 baseline
    send(8'hA5, 4'd8, 1, 0, 2'b01, 1, 16'd3, 0);   // R4 even
    send(8'hA4, 4'd8, 1, 1, 2'b10, 1, 16'd3, 0);   // R4 odd, R5 two stops
    send(8'hFF, 4'd5, 1, 0, 2'b00, 0, 16'd2, 0);   // R4 over active bits only, low idle
    send(8'h3C, 4'd6, 0, 0, 2'b11, 0, 16'd1, 0);   // R5 code 11
    send(8'hC3, 4'd7, 1, 1, 2'b10, 1, 16'd5, 0);
    send(8'h9E, 4'd3, 1, 0, 2'b01, 1, 16'd2, 0);   // R3 clamp low
    send(8'h81, 4'd12, 1, 1, 2'b01, 1, 16'd2, 0);  // R3 clamp high
    send(8'h5A, 4'd8, 0, 0, 2'b01, 1, 16'd0, 0);   // R6 zero period
    send(8'h17, 4'd7, 1, 0, 2'b10, 0, 16'd4, 1);   // R8 scramble
    send(8'hE2, 4'd5, 0, 1, 2'b01, 1, 16'd6, 1);   // R8 scramble
    // R1: idle level follows input while idle
    cfg_idle_i = 1'b0; repeat (3) @(negedge clk_i);
    cfg_idle_i = 1'b1; repeat (3) @(negedge clk_i);
    // R7: back-to-back with valid held high
    cfg_width_i = 4'd8; cfg_par_en_i = 0; cfg_stop_i = 2'b01; cfg_idle_i = 1; cfg_period_i = 16'd2;
    in_data_i = 8'h11; in_valid_i = 1'b1;
    begin
      automatic int a0 = acc_cnt;
      do @(negedge clk_i); while (acc_cnt == a0);
      in_data_i = 8'hEE;
      a0 = acc_cnt;
      do @(negedge clk_i); while (acc_cnt == a0);
      in_valid_i = 1'b0;
    end
    while (bit_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule